// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This core keeps the time of day and the calendar in BCD counters (seconds, minutes, hours, day of week, day of month, month, year and century) and presents a second, user-visible copy of those values in a small register window reached over a byte-wide bus. A one-second strobe from an external divider advances the counters. While updating is allowed, every strobe refreshes all user copies at once, so a reader never sees a half-updated time.

Two control bits let software freeze the user copies. The read-freeze bit holds a stable snapshot while the counters keep running behind it. The write-freeze bit does the same, and its release copies the values software placed in the user registers into the counters. A stop bit kept in the top of the seconds register suspends timekeeping without any freeze. Month lengths, leap Februaries and the year and century roll-over are handled by the advance logic.

Top module: `rtc_calendar_core`

## Requirements
- R1: The window offset selects the register: 0 flags, 1 century, 8 control, 9 seconds, 10 minutes, 11 hours, 12 day of week, 13 day of month, 14 month, 15 year; control bit 7 is the write-freeze bit and bit 6 the read-freeze bit.
- R2: Each strobe adds one second in BCD; seconds and minutes wrap from 59 to 00 and carry; hours wrap from 23 to 00 and carry to both the day of week (07 wraps to 01) and the day of month.
- R3: Months 04, 06, 09 and 11 end after day 30; months 01, 03, 05, 07, 08, 10 and 12 end after day 31; the day after the last is day 01 of the next month.
- R4: February ends after day 28, or after day 29 when the BCD year is a multiple of four (00 included), regardless of century.
- R5: December 31 rolls to January 1; year 99 wraps to 00 and increments the century, and century 99 with year 99 wraps both to 00.
- R6: While the read-freeze bit is 1, the user copies hold their values and the counters keep advancing; clearing it leaves the copies unchanged until the next strobe, which shows the counter value including the strobes seen while frozen.
- R7: While the write-freeze bit is 1, bus writes to the time registers stay in the user copies and strobes do not overwrite them; clearing the bit loads all user time values into the counters in that cycle, and the next strobe shows the loaded time plus one second.
- R8: When not frozen, one strobe refreshes all user time registers in the same cycle; a strobe arriving in the same cycle as a write that sets a freeze bit still completes its refresh.
- R9: Seconds register bit 7 is a stop bit, writable without the write-freeze bit and read back; while it is 1 strobes are ignored, and after it is cleared the next strobe advances the time.
- R10: After reset both freeze bits and the stop bit are 0 and the time reads century 00, year 00, month 01, date 01, day 01, 00:00:00.
- R11: Bit positions with no field read 0: seconds bits 6:0 hold the value, minutes 6:0, hours 5:0, day 2:0, date 5:0, month 4:0, control 5:0 read 0, and offsets 0 and 2 to 7 read 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| cs | input | 1 | Register window select |
| we | input | 1 | Write strobe, valid with cs |
| addr | input | ADDR_W | Offset inside the 16-byte window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the user copies, 0 when not selected or writing |

## Verification
The hardest situation to reach is a divergence between the counters and the user copies, since the counters are never visible directly. The bench creates it by freezing, applying several strobes, and then releasing: the value shown after the next strobe reveals how far the hidden counters moved. The coincidence of a strobe with the freeze-setting write is driven in one cycle by a dedicated task, and calendar edges such as leap Februaries and the century wrap are reached by loading the counters through a write-freeze release just before the boundary.

// File: rtl/rtc_pkg.sv
// Package: shared types and constants of the calendar clock core.
// Assumes all time fields are stored as 8-bit BCD bytes.
package rtc_pkg;

    typedef struct packed {
        logic [7:0] cen;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam int unsigned OFS_FLAG = 0;
    localparam int unsigned OFS_CEN  = 1;
    localparam int unsigned OFS_CTRL = 8;
    localparam int unsigned OFS_SEC  = 9;
    localparam int unsigned OFS_MIN  = 10;
    localparam int unsigned OFS_HR   = 11;
    localparam int unsigned OFS_DAY  = 12;
    localparam int unsigned OFS_DATE = 13;
    localparam int unsigned OFS_MON  = 14;
    localparam int unsigned OFS_YR   = 15;

    localparam logic [7:0] MASK_SEC  = 8'h7F;
    localparam logic [7:0] MASK_MIN  = 8'h7F;
    localparam logic [7:0] MASK_HR   = 8'h3F;
    localparam logic [7:0] MASK_DAY  = 8'h07;
    localparam logic [7:0] MASK_DATE = 8'h3F;
    localparam logic [7:0] MASK_MON  = 8'h1F;

    localparam rtc_time_t TIME_RESET = '{
        cen: 8'h00, yr: 8'h00, mon: 8'h01, date: 8'h01,
        day: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00
    };

endpackage

// File: rtl/rtc_bcd_wrap.sv
// Module: one BCD field stage with a programmable range.
// When enabled, the field steps by one in BCD; at or above the upper
// bound it returns to the lower bound and raises its carry.
// Assumes cur holds a BCD value (an out-of-range value wraps on its next step).
module rtc_bcd_wrap #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         en,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    localparam int DIGITS = W / 4;

    logic         at_top;
    logic [W-1:0] inc;

    // Ripple a +1 through the BCD digits.
    always_comb begin
        logic carry;
        carry = 1'b1;
        inc   = cur;
        for (int d = 0; d < DIGITS; d++) begin
            if (carry) begin
                if (cur[d*4 +: 4] >= 4'd9) begin
                    inc[d*4 +: 4] = 4'd0;
                end else begin
                    inc[d*4 +: 4] = cur[d*4 +: 4] + 4'd1;
                    carry = 1'b0;
                end
            end
        end
    end

    // Select hold, step or wrap.
    always_comb begin
        at_top = (cur >= hi);
        wrap   = en && at_top;
        if (!en)        nxt = cur;
        else if (at_top) nxt = lo;
        else            nxt = inc;
    end
endmodule

// File: rtl/rtc_month_len.sv
// Module: last valid day of the month in BCD.
// Leap rule: BCD year divisible by four (valid while the century is
// not a multiple of 100 exceptions, i.e. through 2099).
module rtc_month_len (
    input  logic [7:0] mon,
    input  logic [7:0] yr,
    output logic [7:0] last_day
);
    logic leap;

    // Divisibility by four read straight from the two BCD digits.
    always_comb begin
        if (yr[4]) leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else       leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    end

    // Month length table in BCD.
    always_comb begin
        case (mon)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_time_advance.sv
// Module: combinational one-second advance of the full calendar.
// Chains field stages so each carry enables the next coarser field;
// the hour carry feeds both day-of-week and day-of-month.
module rtc_time_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      step,
    output rtc_time_t nxt
);
    logic c_sec, c_min, c_hr, c_day, c_date, c_mon, c_yr, c_cen;
    logic [7:0] last_day;

    rtc_month_len u_mlen (.mon(cur.mon), .yr(cur.yr), .last_day(last_day));

    rtc_bcd_wrap u_sec  (.cur(cur.sec),  .lo(8'h00), .hi(8'h59),   .en(step),   .nxt(nxt.sec),  .wrap(c_sec));
    rtc_bcd_wrap u_min  (.cur(cur.min),  .lo(8'h00), .hi(8'h59),   .en(c_sec),  .nxt(nxt.min),  .wrap(c_min));
    rtc_bcd_wrap u_hr   (.cur(cur.hr),   .lo(8'h00), .hi(8'h23),   .en(c_min),  .nxt(nxt.hr),   .wrap(c_hr));
    rtc_bcd_wrap u_day  (.cur(cur.day),  .lo(8'h01), .hi(8'h07),   .en(c_hr),   .nxt(nxt.day),  .wrap(c_day));
    rtc_bcd_wrap u_date (.cur(cur.date), .lo(8'h01), .hi(last_day), .en(c_hr),  .nxt(nxt.date), .wrap(c_date));
    rtc_bcd_wrap u_mon  (.cur(cur.mon),  .lo(8'h01), .hi(8'h12),   .en(c_date), .nxt(nxt.mon),  .wrap(c_mon));
    rtc_bcd_wrap u_yr   (.cur(cur.yr),   .lo(8'h00), .hi(8'h99),   .en(c_mon),  .nxt(nxt.yr),   .wrap(c_yr));
    rtc_bcd_wrap u_cen  (.cur(cur.cen),  .lo(8'h00), .hi(8'h99),   .en(c_yr),   .nxt(nxt.cen),  .wrap(c_cen));

    // Day-of-week and century carries end the chain.
    logic unused_carry;
    always_comb unused_carry = c_day ^ c_cen;
endmodule

// File: rtl/rtc_calendar_core.sv
// Module: calendar clock core with hidden counters and user copies.
// Counters advance on tick unless stopped; user copies follow them while
// no freeze bit is set. Freeze decisions use the control bits held before
// the current cycle, so a refresh coinciding with a freeze write completes.
// Assumes tick is a single-cycle pulse.
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_CEN  = ADDR_W'(OFS_CEN);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFS_SEC);
    localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(OFS_MIN);
    localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(OFS_HR);
    localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(OFS_DAY);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFS_DATE);
    localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(OFS_MON);
    localparam logic [ADDR_W-1:0] A_YR   = ADDR_W'(OFS_YR);

    rtc_time_t cnt_q, usr_q, cnt_nxt;
    logic      ctrl_w_q, ctrl_r_q, stop_q;
    logic      wr, wr_ctrl, w_release, frozen, adv;

    rtc_time_advance u_adv (.cur(cnt_q), .step(1'b1), .nxt(cnt_nxt));

    // Decode bus writes and the per-cycle advance conditions.
    always_comb begin
        wr        = cs && we;
        wr_ctrl   = wr && (addr == A_CTRL);
        w_release = wr_ctrl && ctrl_w_q && !wdata[7];
        frozen    = ctrl_w_q || ctrl_r_q;
        adv       = tick && !stop_q;
    end

    // Control bits and stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_w_q <= 1'b0;
            ctrl_r_q <= 1'b0;
            stop_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_w_q <= wdata[7];
                ctrl_r_q <= wdata[6];
            end
            if (wr && addr == A_SEC) stop_q <= wdata[7];
        end
    end

    // Hidden counters: load on write-freeze release, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= TIME_RESET;
        else if (w_release) cnt_q <= usr_q;
        else if (adv)       cnt_q <= cnt_nxt;
    end

    // User copies: refresh from the advanced counters, else take bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr_q <= TIME_RESET;
        end else if (adv && !frozen) begin
            usr_q <= cnt_nxt;
        end else if (wr) begin
            case (addr)
                A_SEC:   usr_q.sec  <= wdata & MASK_SEC;
                A_MIN:   usr_q.min  <= wdata & MASK_MIN;
                A_HR:    usr_q.hr   <= wdata & MASK_HR;
                A_DAY:   usr_q.day  <= wdata & MASK_DAY;
                A_DATE:  usr_q.date <= wdata & MASK_DATE;
                A_MON:   usr_q.mon  <= wdata & MASK_MON;
                A_YR:    usr_q.yr   <= wdata;
                A_CEN:   usr_q.cen  <= wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer over the user copies.
    always_comb begin
        rdata = 8'h00;
        if (cs && !we) begin
            case (addr)
                A_FLAG:  rdata = 8'h00;
                A_CEN:   rdata = usr_q.cen;
                A_CTRL:  rdata = {ctrl_w_q, ctrl_r_q, 6'b0};
                A_SEC:   rdata = {stop_q, usr_q.sec[6:0]};
                A_MIN:   rdata = usr_q.min;
                A_HR:    rdata = usr_q.hr;
                A_DAY:   rdata = usr_q.day;
                A_DATE:  rdata = usr_q.date;
                A_MON:   rdata = usr_q.mon;
                A_YR:    rdata = usr_q.yr;
                default: rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
// Checker: temporal properties of the calendar core, bound to its internals.
module rtc_calendar_chk
    import rtc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      wr,
    input logic      frozen,
    input logic      adv,
    input logic      w_release,
    input logic      stop_q,
    input logic      ctrl_r_q,
    input logic      ctrl_w_q,
    input rtc_time_t cnt_q,
    input rtc_time_t usr_q
);
    // R6: frozen copies do not change without a bus write.
    a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !wr) |=> $stable(usr_q));

    // R6: counters move on every accepted strobe, frozen or not.
    a_r6_counters_run: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !w_release) |=> (cnt_q != $past(cnt_q)));

    // R9: a set stop bit holds the counters.
    a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !w_release) |=> $stable(cnt_q));

    // R10: freeze bits are clear as reset ends.
    a_r10_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ctrl_r_q && !ctrl_w_q));

    // R8: an unfrozen strobe leaves copies equal to the counters.
    a_r8_refresh_all: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !frozen) |=> (usr_q == cnt_q));

    // R7: releasing write-freeze loads the user values.
    a_r7_load_back: assert property (@(posedge clk) disable iff (!rst_n)
        w_release |=> (cnt_q == $past(usr_q)));
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr(wr), .frozen(frozen), .adv(adv),
    .w_release(w_release), .stop_q(stop_q), .ctrl_r_q(ctrl_r_q),
    .ctrl_w_q(ctrl_w_q), .cnt_q(cnt_q), .usr_q(usr_q)
);

// File: tb/rtc_calendar_core_bench.sv
`timescale 1ns/1ps
// Directed bench for the calendar clock core.
module rtc_calendar_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rtc_calendar_core #(.ADDR_W(4)) u_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        cs = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        cs = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] cen, yr, mon, date, day, hr, mn, sec);
        wr(4'd8, 8'h80);
        wr(4'd1, cen);  wr(4'd15, yr); wr(4'd14, mon); wr(4'd13, date);
        wr(4'd12, day); wr(4'd11, hr); wr(4'd10, mn);  wr(4'd9, sec);
        wr(4'd8, 8'h00);
    endtask

    task automatic t_reset();
        expect_reg("R10 ctrl", 4'd8, 8'h00);
        expect_reg("R10 sec", 4'd9, 8'h00);
        expect_reg("R10 min", 4'd10, 8'h00);
        expect_reg("R10 hr", 4'd11, 8'h00);
        expect_reg("R10 day", 4'd12, 8'h01);
        expect_reg("R10 date", 4'd13, 8'h01);
        expect_reg("R10 mon", 4'd14, 8'h01);
        expect_reg("R10 yr", 4'd15, 8'h00);
        expect_reg("R10 cen", 4'd1, 8'h00);
    endtask

    task automatic t_map();
        set_time(8'h20, 8'h31, 8'h07, 8'h19, 8'h05, 8'h14, 8'h27, 8'h38);
        expect_reg("R1 cen", 4'd1, 8'h20);
        expect_reg("R1 yr", 4'd15, 8'h31);
        expect_reg("R1 mon", 4'd14, 8'h07);
        expect_reg("R1 date", 4'd13, 8'h19);
        expect_reg("R1 day", 4'd12, 8'h05);
        expect_reg("R1 hr", 4'd11, 8'h14);
        expect_reg("R1 min", 4'd10, 8'h27);
        expect_reg("R1 sec", 4'd9, 8'h38);
        wr(4'd8, 8'h80);
        expect_reg("R1 ctrl write bit", 4'd8, 8'h80);
        wr(4'd8, 8'h00);
    endtask

    task automatic t_zero_bits();
        wr(4'd8, 8'hBF);
        expect_reg("R11 ctrl low bits", 4'd8, 8'h80);
        for (int a = 10; a <= 14; a++) wr(4'(a), 8'hFF);
        expect_reg("R11 min mask", 4'd10, 8'h7F);
        expect_reg("R11 hr mask", 4'd11, 8'h3F);
        expect_reg("R11 day mask", 4'd12, 8'h07);
        expect_reg("R11 date mask", 4'd13, 8'h3F);
        expect_reg("R11 mon mask", 4'd14, 8'h1F);
        for (int a = 0; a <= 7; a++) begin
            if (a != 1) begin
                wr(4'(a), 8'hFF);
                expect_reg($sformatf("R11 offset %0d", a), 4'(a), 8'h00);
            end
        end
        wr(4'd8, 8'h00);
    endtask

    task automatic t_roll_hms();
        set_time(8'h20, 8'h21, 8'h05, 8'h10, 8'h07, 8'h23, 8'h59, 8'h58);
        pulse(1);
        expect_reg("R2 sec step", 4'd9, 8'h59);
        pulse(1);
        expect_reg("R2 sec wrap", 4'd9, 8'h00);
        expect_reg("R2 min wrap", 4'd10, 8'h00);
        expect_reg("R2 hr wrap", 4'd11, 8'h00);
        expect_reg("R2 day wrap", 4'd12, 8'h01);
        expect_reg("R2 date carry", 4'd13, 8'h11);
        set_time(8'h20, 8'h21, 8'h05, 8'h10, 8'h02, 8'h09, 8'h19, 8'h59);
        pulse(1);
        expect_reg("R2 BCD digit carry", 4'd10, 8'h20);
        expect_reg("R2 hr hold", 4'd11, 8'h09);
    endtask

    task automatic month_end(input string req, input logic [7:0] yr, mon, date,
                             input logic [7:0] exp_mon, exp_date);
        set_time(8'h20, yr, mon, date, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse(1);
        expect_reg({req, " month"}, 4'd14, exp_mon);
        expect_reg({req, " date"}, 4'd13, exp_date);
    endtask

    task automatic t_months();
        month_end("R3 apr30", 8'h22, 8'h04, 8'h30, 8'h05, 8'h01);
        month_end("R3 nov30", 8'h22, 8'h11, 8'h30, 8'h12, 8'h01);
        month_end("R3 jan30", 8'h22, 8'h01, 8'h30, 8'h01, 8'h31);
        month_end("R3 jan31", 8'h22, 8'h01, 8'h31, 8'h02, 8'h01);
        month_end("R3 aug31", 8'h22, 8'h08, 8'h31, 8'h09, 8'h01);
    endtask

    task automatic t_feb();
        month_end("R4 y23", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
        month_end("R4 y24", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
        month_end("R4 y24 end", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
        month_end("R4 y00", 8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
        month_end("R4 y10", 8'h10, 8'h02, 8'h28, 8'h03, 8'h01);
        month_end("R4 y12", 8'h12, 8'h02, 8'h28, 8'h02, 8'h29);
    endtask

    task automatic t_year();
        set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse(1);
        expect_reg("R5 year wrap", 4'd15, 8'h00);
        expect_reg("R5 century inc", 4'd1, 8'h20);
        expect_reg("R5 month", 4'd14, 8'h01);
        expect_reg("R5 date", 4'd13, 8'h01);
        expect_reg("R5 day", 4'd12, 8'h04);
        set_time(8'h99, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        pulse(1);
        expect_reg("R5 both wrap year", 4'd15, 8'h00);
        expect_reg("R5 both wrap century", 4'd1, 8'h00);
        set_time(8'h20, 8'h41, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        pulse(1);
        expect_reg("R5 year inc", 4'd15, 8'h42);
        expect_reg("R5 century hold", 4'd1, 8'h20);
    endtask

    task automatic t_read_freeze();
        set_time(8'h20, 8'h30, 8'h06, 8'h15, 8'h02, 8'h10, 8'h20, 8'h30);
        cs = 1'b1; we = 1'b1; addr = 4'd8; wdata = 8'h40; tick = 1'b1;
        @(posedge clk); #1;
        cs = 1'b0; we = 1'b0; tick = 1'b0;
        expect_reg("R8 refresh with freeze write", 4'd9, 8'h31);
        expect_reg("R1 ctrl read bit", 4'd8, 8'h40);
        pulse(3);
        expect_reg("R6 frozen sec", 4'd9, 8'h31);
        expect_reg("R6 frozen min", 4'd10, 8'h20);
        wr(4'd8, 8'h00);
        expect_reg("R6 stale after release", 4'd9, 8'h31);
        pulse(1);
        expect_reg("R6 counters kept running", 4'd9, 8'h35);
    endtask

    task automatic t_write_load();
        set_time(8'h20, 8'h30, 8'h06, 8'h15, 8'h02, 8'h10, 8'h20, 8'h30);
        wr(4'd8, 8'h80);
        pulse(1);
        wr(4'd9, 8'h45);
        wr(4'd10, 8'h12);
        pulse(2);
        expect_reg("R7 held sec", 4'd9, 8'h45);
        expect_reg("R7 held min", 4'd10, 8'h12);
        wr(4'd8, 8'h00);
        expect_reg("R7 after release", 4'd9, 8'h45);
        pulse(1);
        expect_reg("R7 loaded plus one", 4'd9, 8'h46);
        expect_reg("R7 loaded min", 4'd10, 8'h12);
        expect_reg("R7 hr kept", 4'd11, 8'h10);
    endtask

    task automatic t_stop();
        set_time(8'h20, 8'h30, 8'h06, 8'h15, 8'h02, 8'h10, 8'h20, 8'h10);
        wr(4'd9, 8'h90);
        expect_reg("R9 stop readback", 4'd9, 8'h90);
        pulse(3);
        expect_reg("R9 stopped", 4'd9, 8'h90);
        wr(4'd9, 8'h10);
        expect_reg("R9 cleared", 4'd9, 8'h10);
        pulse(1);
        expect_reg("R9 restart", 4'd9, 8'h11);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_map();
        t_zero_bits();
        t_roll_hms();
        t_months();
        t_feb();
        t_year();
        t_read_freeze();
        t_write_load();
        t_stop();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule